// File: doc/BRIEF.md
# Shared-Timebase Capture/Compare Array

This block has one free-running 16-bit up-counter that acts as the time reference for several independent 16-bit capture/compare channels. The default is five channels. A two-bit field chooses what advances the counter. It can be a divided oscillator tick (divided by six or by twelve), an overflow pulse from a neighbouring timer, or the rising edges of an external count pin. The counter only moves while a run bit is set. When it passes 0xFFFF it wraps to zero and raises a sticky overflow flag.

Each channel owns one pin and works in one of these modes:
- **Edge capture:** on a rising edge, a falling edge or either edge of the pin, the channel stores the counter value and raises its event flag.
- **Software timer:** the event flag rises when the counter reaches the channel's compare value.
- **Toggle output:** the pin inverts on each match and the flag rises.
- **8-bit PWM:** the pin level is set by comparing the counter's low byte with a double-buffered duty byte.

Software reaches all of this through a byte-wide register port. Writes are synchronous and reads are combinational.

Top module: `capcmp_array`

## Requirements
- R1: After reset the counter is 0, the overflow flag is 0, every event flag is 0 and every channel pin is low.
- R2: Each selected count event advances the counter by exactly one, but only while the run bit (bit 0 of the control register at address 0) is 1. With the run bit 0 the counter holds its value.
- R3: Control bits [2:1] choose the count event. The encodings are 0 = every 6th oscillator tick, 1 = every 12th oscillator tick, 2 = each cycle the timer-0 overflow input is high, 3 = each rising edge of the external count pin after two-flop synchronisation. Events from the sources that are not selected do not move the counter.
- R4: A count event at 0xFFFF gives 0x0000 and sets the overflow flag (control bit 3). Writing the control register with bit 3 = 0 clears the flag, and writing it with bit 3 = 1 leaves the flag unchanged.
- R5: The register map is: address 0 control (reads {0000, ovf, src[1:0], run}); address 1 counter low byte; address 2 counter high byte; address 3 event flags (bit n = channel n); and for channel n, address 8+4n mode (bits [2:0]), 9+4n compare/capture low byte, 10+4n high byte. Every field reads back what was written.
- R6: The mode codes for capture are 1 (rising), 2 (falling) and 3 (both). On a qualifying edge of the synchronised pin, the channel's 16-bit register takes the counter value and the channel's flag sets. An edge of the other polarity changes neither the register nor the flag.
- R7: Writing the flag register clears each flag whose data bit is 0 and leaves each flag whose data bit is 1 unchanged. No other event clears a flag.
- R8: Mode 4 (software timer) sets the channel flag on a count event taken while the counter equals the channel's 16-bit compare value. The pin is not affected. A channel in mode 0 keeps its pin low.
- R9: Mode 5 (toggle output) inverts the channel pin and sets the flag on each such match.
- R10: Mode 6 (PWM) drives the pin low while the counter's low byte is below the active duty byte, and high otherwise. The active duty byte starts at 0. It is loaded from the channel's compare high byte on each count event taken while the low byte is 0xFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| oscTick | input | 1 | One-cycle pulse per oscillator period |
| t0Ovf | input | 1 | Timer-0 overflow pulse |
| extCnt | input | 1 | Asynchronous external count pin |
| modPinIn | input | NUM_MOD | Asynchronous capture pins, one per channel |
| regAddr | input | ADDR_W | Register address |
| regWr | input | 1 | Register write strobe |
| regWrData | input | 8 | Register write data |
| regRdData | output | 8 | Register read data (combinational) |
| modPinOut | output | NUM_MOD | Channel output pins |
| cntValue | output | 16 | Current counter value |
| modFlag | output | NUM_MOD | Per-channel event flags |
| cntOvf | output | 1 | Counter overflow flag |

## Verification
The bench builds the block with its default parameters: five channels, a 5-bit address and prescale divisors of 6 and 12. These give every channel an address and place the highest channel at the top of the map. Most steps use the timer-0 source. With that input held high the counter advances once per cycle, so exact counter values can be reached directly. That covers both the low-byte wrap that reloads the PWM duty byte and the full 16-bit wrap, which still fits well inside the cycle budget.

// File: rtl/capcmp_pkg.sv
package capcmp_pkg;
  localparam int CNT_W  = 16;
  localparam int BYTE_W = 8;
  localparam int MODE_W = 3;
  localparam int IDX_W  = 4;

  typedef enum logic [MODE_W-1:0] {
    MD_OFF      = 3'd0,
    MD_CAP_RISE = 3'd1,
    MD_CAP_FALL = 3'd2,
    MD_CAP_BOTH = 3'd3,
    MD_SWTIMER  = 3'd4,
    MD_TOGGLE   = 3'd5,
    MD_PWM      = 3'd6,
    MD_SPARE    = 3'd7
  } mode_e;

  // strobes from control to datapath, valid for one cycle
  typedef struct packed {
    logic              tick;
    logic              wrLo;
    logic              wrHi;
    logic              wrFlag;
    logic              wrOvf;
    logic [IDX_W-1:0]  modIdx;
    logic [BYTE_W-1:0] data;
  } strobe_t;
endpackage

// File: rtl/capcmp_ctrl.sv
module capcmp_ctrl
  import capcmp_pkg::*;
#(
  parameter int NUM_MOD  = 5,
  parameter int ADDR_W   = 5,
  parameter int DIV_FAST = 6,
  parameter int DIV_SLOW = 12
) (
  input  logic                             clk,
  input  logic                             rstN,
  input  logic                             oscTick,
  input  logic                             t0Ovf,
  input  logic                             extCnt,
  input  logic [ADDR_W-1:0]                regAddr,
  input  logic                             regWr,
  input  logic [BYTE_W-1:0]                regWrData,
  input  logic [CNT_W-1:0]                 cntValue,
  input  logic                             cntOvf,
  input  logic [NUM_MOD-1:0]               modFlag,
  input  logic [NUM_MOD-1:0][CNT_W-1:0]    cmpValue,
  output logic [BYTE_W-1:0]                regRdData,
  output strobe_t                          stb,
  output logic                             runEn,
  output mode_e [NUM_MOD-1:0]              modeArr
);
  localparam int IDXW  = ADDR_W - 2;
  localparam int PRE_W = $clog2(DIV_SLOW);
  localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] A_CLO  = ADDR_W'(1);
  localparam logic [ADDR_W-1:0] A_CHI  = ADDR_W'(2);
  localparam logic [ADDR_W-1:0] A_FLAG = ADDR_W'(3);
  localparam logic [ADDR_W-1:0] A_MOD  = ADDR_W'(8);
  localparam logic [IDXW-1:0]   NMOD_L = IDXW'(NUM_MOD);
  localparam logic [PRE_W-1:0]  END_FAST = PRE_W'(DIV_FAST - 1);
  localparam logic [PRE_W-1:0]  END_SLOW = PRE_W'(DIV_SLOW - 1);

  logic [1:0]        srcSel;
  logic [ADDR_W-1:0] offs;
  logic [IDXW-1:0]   idx;
  logic [1:0]        sub;
  logic              idxOk;

  assign offs  = regAddr - A_MOD;
  assign idx   = offs[ADDR_W-1:2];
  assign sub   = offs[1:0];
  assign idxOk = (regAddr >= A_MOD) && (idx < NMOD_L);

  // configuration registers
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      runEn   <= 1'b0;
      srcSel  <= 2'd0;
      modeArr <= '{default: MD_OFF};
    end else if (regWr) begin
      if (regAddr == A_CTRL) begin
        runEn  <= regWrData[0];
        srcSel <= regWrData[2:1];
      end
      if (idxOk && sub == 2'd0) modeArr[idx] <= mode_e'(regWrData[MODE_W-1:0]);
    end
  end

  // count source: prescaler and external pin synchroniser
  logic [PRE_W-1:0] pre;
  logic [PRE_W-1:0] preEnd;
  logic             preHit;
  logic             extS1, extS2, extPrev;
  logic             rawTick;

  assign preEnd = (srcSel == 2'd0) ? END_FAST : END_SLOW;
  assign preHit = oscTick && (pre == preEnd);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pre     <= '0;
      extS1   <= 1'b0;
      extS2   <= 1'b0;
      extPrev <= 1'b0;
    end else begin
      extS1   <= extCnt;
      extS2   <= extS1;
      extPrev <= extS2;
      if (oscTick) pre <= (pre >= preEnd) ? '0 : pre + 1'b1;
    end
  end

  always_comb begin
    unique case (srcSel)
      2'd0, 2'd1: rawTick = preHit;
      2'd2:       rawTick = t0Ovf;
      default:    rawTick = extS2 && !extPrev;
    endcase
  end

  assign stb.tick   = runEn && rawTick;
  assign stb.wrLo   = regWr && idxOk && (sub == 2'd1);
  assign stb.wrHi   = regWr && idxOk && (sub == 2'd2);
  assign stb.wrFlag = regWr && (regAddr == A_FLAG);
  assign stb.wrOvf  = regWr && (regAddr == A_CTRL);
  assign stb.modIdx = IDX_W'(idx);
  assign stb.data   = regWrData;

  // read mux
  always_comb begin
    regRdData = '0;
    if (regAddr == A_CTRL)      regRdData = {4'b0, cntOvf, srcSel, runEn};
    else if (regAddr == A_CLO)  regRdData = cntValue[BYTE_W-1:0];
    else if (regAddr == A_CHI)  regRdData = cntValue[CNT_W-1:BYTE_W];
    else if (regAddr == A_FLAG) regRdData = BYTE_W'(modFlag);
    else if (idxOk) begin
      case (sub)
        2'd0:    regRdData = {{(BYTE_W-MODE_W){1'b0}}, modeArr[idx]};
        2'd1:    regRdData = cmpValue[idx][BYTE_W-1:0];
        2'd2:    regRdData = cmpValue[idx][CNT_W-1:BYTE_W];
        default: regRdData = '0;
      endcase
    end
  end
endmodule

// File: rtl/capcmp_dpath.sv
module capcmp_dpath
  import capcmp_pkg::*;
#(
  parameter int NUM_MOD = 5
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  strobe_t                       stb,
  input  mode_e [NUM_MOD-1:0]           modeArr,
  input  logic [NUM_MOD-1:0]            modPinIn,
  output logic [CNT_W-1:0]              cntValue,
  output logic                          cntOvf,
  output logic [NUM_MOD-1:0][CNT_W-1:0] cmpValue,
  output logic [NUM_MOD-1:0]            modFlag,
  output logic [NUM_MOD-1:0]            modPinOut
);
  logic lowWrap;
  assign lowWrap = stb.tick && (cntValue[BYTE_W-1:0] == '1);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cntValue <= '0;
      cntOvf   <= 1'b0;
    end else begin
      if (stb.tick) cntValue <= cntValue + 1'b1;
      if (stb.tick && cntValue == '1)     cntOvf <= 1'b1;
      else if (stb.wrOvf && !stb.data[3]) cntOvf <= 1'b0;
    end
  end

  for (genvar g = 0; g < NUM_MOD; g++) begin : g_mod
    logic              s1, s2, prev;
    logic              rise, fall, capHit, cmpHit, evHit, sel;
    logic [CNT_W-1:0]  cmpReg;
    logic              flagReg, togReg;
    logic [BYTE_W-1:0] duty;
    mode_e             md;

    assign md     = modeArr[g];
    assign rise   = s2 && !prev;
    assign fall   = !s2 && prev;
    assign capHit = (md == MD_CAP_RISE && rise) || (md == MD_CAP_FALL && fall) ||
                    (md == MD_CAP_BOTH && (rise || fall));
    assign cmpHit = stb.tick && (cntValue == cmpReg);
    assign evHit  = capHit || (cmpHit && (md == MD_SWTIMER || md == MD_TOGGLE));
    assign sel    = (stb.modIdx == IDX_W'(g));

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        s1      <= 1'b0;
        s2      <= 1'b0;
        prev    <= 1'b0;
        cmpReg  <= '0;
        flagReg <= 1'b0;
        togReg  <= 1'b0;
        duty    <= '0;
      end else begin
        s1   <= modPinIn[g];
        s2   <= s1;
        prev <= s2;
        if (capHit) cmpReg <= cntValue;
        else begin
          if (stb.wrLo && sel) cmpReg[BYTE_W-1:0]     <= stb.data;
          if (stb.wrHi && sel) cmpReg[CNT_W-1:BYTE_W] <= stb.data;
        end
        if (evHit) flagReg <= 1'b1;
        else if (stb.wrFlag && !stb.data[g]) flagReg <= 1'b0;
        if (cmpHit && md == MD_TOGGLE) togReg <= !togReg;
        if (lowWrap) duty <= cmpReg[CNT_W-1:BYTE_W];
      end
    end

    assign cmpValue[g]  = cmpReg;
    assign modFlag[g]   = flagReg;
    assign modPinOut[g] = (md == MD_PWM) ? (cntValue[BYTE_W-1:0] >= duty) : togReg;
  end
endmodule

// File: rtl/capcmp_array.sv
module capcmp_array
  import capcmp_pkg::*;
#(
  parameter int NUM_MOD  = 5,
  parameter int ADDR_W   = 5,
  parameter int DIV_FAST = 6,
  parameter int DIV_SLOW = 12
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               oscTick,
  input  logic               t0Ovf,
  input  logic               extCnt,
  input  logic [NUM_MOD-1:0] modPinIn,
  input  logic [ADDR_W-1:0]  regAddr,
  input  logic               regWr,
  input  logic [7:0]         regWrData,
  output logic [7:0]         regRdData,
  output logic [NUM_MOD-1:0] modPinOut,
  output logic [15:0]        cntValue,
  output logic [NUM_MOD-1:0] modFlag,
  output logic               cntOvf
);
  strobe_t                       stb;
  logic                          runEn;
  mode_e [NUM_MOD-1:0]           modeArr;
  logic [NUM_MOD-1:0][CNT_W-1:0] cmpValue;

  capcmp_ctrl #(
    .NUM_MOD(NUM_MOD), .ADDR_W(ADDR_W), .DIV_FAST(DIV_FAST), .DIV_SLOW(DIV_SLOW)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .oscTick(oscTick), .t0Ovf(t0Ovf), .extCnt(extCnt),
    .regAddr(regAddr), .regWr(regWr), .regWrData(regWrData),
    .cntValue(cntValue), .cntOvf(cntOvf), .modFlag(modFlag), .cmpValue(cmpValue),
    .regRdData(regRdData), .stb(stb), .runEn(runEn), .modeArr(modeArr)
  );

  capcmp_dpath #(.NUM_MOD(NUM_MOD)) u_dpath (
    .clk(clk), .rstN(rstN), .stb(stb), .modeArr(modeArr), .modPinIn(modPinIn),
    .cntValue(cntValue), .cntOvf(cntOvf), .cmpValue(cmpValue),
    .modFlag(modFlag), .modPinOut(modPinOut)
  );
endmodule

// File: rtl/capcmp_array_chk.sv
module capcmp_array_chk
  import capcmp_pkg::*;
#(
  parameter int NUM_MOD = 5
) (
  input logic                clk,
  input logic                rstN,
  input logic                tick,
  input logic                wrFlag,
  input logic                wrOvf,
  input logic [15:0]         cntValue,
  input logic                cntOvf,
  input logic [NUM_MOD-1:0]  modFlag,
  input logic [NUM_MOD-1:0]  modPinOut,
  input mode_e [NUM_MOD-1:0] modeArr
);
  a_r2_step: assert property (@(posedge clk) disable iff (!rstN)
    tick |=> cntValue == $past(cntValue) + 16'd1);

  a_r2_hold: assert property (@(posedge clk) disable iff (!rstN)
    !tick |=> cntValue == $past(cntValue));

  a_r4_wrap: assert property (@(posedge clk) disable iff (!rstN)
    (tick && cntValue == 16'hFFFF) |=> (cntOvf && cntValue == 16'h0000));

  a_r4_ovf_sticky: assert property (@(posedge clk) disable iff (!rstN)
    (cntOvf && !wrOvf) |=> cntOvf);

  a_r7_flag_sticky: assert property (@(posedge clk) disable iff (!rstN)
    !wrFlag |=> ((~modFlag & $past(modFlag)) == '0));

  for (genvar i = 0; i < NUM_MOD; i++) begin : g_pin
    a_r9_pin_steady: assert property (@(posedge clk) disable iff (!rstN)
      (modeArr[i] != MD_PWM && !tick) |=>
        (modeArr[i] == MD_PWM || modPinOut[i] == $past(modPinOut[i])));
  end
endmodule

bind capcmp_array capcmp_array_chk #(.NUM_MOD(NUM_MOD)) u_chk (
  .clk(clk), .rstN(rstN), .tick(stb.tick), .wrFlag(stb.wrFlag), .wrOvf(stb.wrOvf),
  .cntValue(cntValue), .cntOvf(cntOvf), .modFlag(modFlag), .modPinOut(modPinOut),
  .modeArr(modeArr)
);

// File: tb/capcmp_array_tb.sv
`timescale 1ns/1ps
module capcmp_array_tb;
  localparam int NM = 5;
  localparam int AW = 5;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          oscTick = 1'b0, t0Ovf = 1'b0, extCnt = 1'b0;
  logic [NM-1:0] modPinIn = '0;
  logic [AW-1:0] regAddr = '0;
  logic          regWr = 1'b0;
  logic [7:0]    regWrData = '0;
  logic [7:0]    regRdData;
  logic [NM-1:0] modPinOut, modFlag;
  logic [15:0]   cntValue;
  logic          cntOvf;
  int            total = 0;
  int            bad = 0;
  logic [7:0]    rv;

  always #2.5 clk = ~clk;

  capcmp_array #(.NUM_MOD(NM), .ADDR_W(AW)) u_dut (
    .clk(clk), .rstN(rstN), .oscTick(oscTick), .t0Ovf(t0Ovf), .extCnt(extCnt),
    .modPinIn(modPinIn), .regAddr(regAddr), .regWr(regWr), .regWrData(regWrData),
    .regRdData(regRdData), .modPinOut(modPinOut), .cntValue(cntValue),
    .modFlag(modFlag), .cntOvf(cntOvf)
  );

  // {write, addr[4:0], data[7:0], expected read[7:0]}
  localparam int NV = 13;
  localparam logic [21:0] VEC [NV] = '{
    {1'b1, 5'd0,  8'h04, 8'h00}, {1'b0, 5'd0,  8'h00, 8'h04},
    {1'b1, 5'd8,  8'h04, 8'h00}, {1'b0, 5'd8,  8'h00, 8'h04},
    {1'b1, 5'd9,  8'h34, 8'h00}, {1'b0, 5'd9,  8'h00, 8'h34},
    {1'b1, 5'd10, 8'h12, 8'h00}, {1'b0, 5'd10, 8'h00, 8'h12},
    {1'b1, 5'd24, 8'h06, 8'h00}, {1'b0, 5'd24, 8'h00, 8'h06},
    {1'b0, 5'd1,  8'h00, 8'h00}, {1'b0, 5'd2,  8'h00, 8'h00},
    {1'b0, 5'd3,  8'h00, 8'h00}
  };

  task automatic check(input logic [31:0] act, input logic [31:0] exp, input string req);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wrReg(input logic [AW-1:0] a, input logic [7:0] d);
    @(negedge clk);
    regAddr = a; regWr = 1'b1; regWrData = d;
    @(negedge clk);
    regWr = 1'b0;
  endtask

  task automatic rdReg(input logic [AW-1:0] a, output logic [7:0] d);
    @(negedge clk);
    regAddr = a;
    #1;
    d = regRdData;
  endtask

  task automatic t0Ticks(input int n);
    @(negedge clk);
    t0Ovf = 1'b1;
    repeat (n) @(negedge clk);
    t0Ovf = 1'b0;
  endtask

  task automatic pinSet(input int ch, input logic v);
    @(negedge clk);
    modPinIn[ch] = v;
    repeat (4) @(negedge clk);
  endtask

  initial begin
    #1_000_000;
    bad++;
    total++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    // R1 reset state
    check(cntValue, 0, "R1 count");
    check(cntOvf, 0, "R1 ovf");
    check(modFlag, 0, "R1 flags");
    check(modPinOut, 0, "R1 pins");

    // R5 register readback table
    for (int i = 0; i < NV; i++) begin
      if (VEC[i][21]) wrReg(VEC[i][20:16], VEC[i][15:8]);
      else begin
        rdReg(VEC[i][20:16], rv);
        check(rv, VEC[i][7:0], "R5 readback");
      end
    end

    // R2 run gating
    wrReg(0, 8'h04);
    t0Ticks(3);
    check(cntValue, 0, "R2 held while stopped");
    wrReg(0, 8'h05);
    t0Ticks(3);
    check(cntValue, 3, "R2 counts while running");
    rdReg(1, rv);
    check(rv, 8'h03, "R2 low byte read");

    // R3 source selection
    wrReg(0, 8'h01);
    @(negedge clk); oscTick = 1'b1;
    repeat (12) @(negedge clk);
    oscTick = 1'b0;
    check(cntValue, 5, "R3 osc/6");
    wrReg(0, 8'h03);
    @(negedge clk); oscTick = 1'b1;
    repeat (24) @(negedge clk);
    oscTick = 1'b0;
    check(cntValue, 7, "R3 osc/12");
    wrReg(0, 8'h07);
    for (int k = 0; k < 2; k++) begin
      @(negedge clk); extCnt = 1'b1;
      repeat (4) @(negedge clk);
      extCnt = 1'b0;
      repeat (4) @(negedge clk);
    end
    check(cntValue, 9, "R3 external rising edges");
    t0Ticks(3);
    check(cntValue, 9, "R3 unselected source ignored");

    // R8 software timer on channel 0
    wrReg(0, 8'h05);
    wrReg(9, 8'h0C);
    wrReg(10, 8'h00);
    t0Ticks(3);
    check(modFlag[0], 0, "R8 no flag before match");
    t0Ticks(1);
    check(modFlag[0], 1, "R8 flag on match");
    check(modPinOut[0], 0, "R8 timer pin unchanged");
    check(modPinOut[3], 0, "R8 idle channel pin low");

    // R7 flag clear semantics
    wrReg(3, 8'hFF);
    check(modFlag[0], 1, "R7 write one keeps flag");
    wrReg(3, 8'h00);
    check(modFlag[0], 0, "R7 write zero clears flag");

    // R9 toggle output on channel 1
    wrReg(12, 8'h05);
    wrReg(13, 8'h10);
    wrReg(14, 8'h00);
    t0Ticks(4);
    check(modPinOut[1], 1, "R9 pin toggled high");
    check(modFlag[1], 1, "R9 flag set");
    wrReg(13, 8'h12);
    t0Ticks(2);
    check(modPinOut[1], 0, "R9 pin toggled low");
    check(cntValue, 16'h13, "R9 count");

    // R6 capture on channel 2
    wrReg(3, 8'h00);
    wrReg(16, 8'h01);
    pinSet(2, 1'b1);
    check(modFlag[2], 1, "R6 rise captured flag");
    rdReg(17, rv);
    check(rv, 8'h13, "R6 rise captured value");
    wrReg(3, 8'h00);
    t0Ticks(2);
    pinSet(2, 1'b0);
    check(modFlag[2], 0, "R6 fall ignored in rise mode");
    rdReg(17, rv);
    check(rv, 8'h13, "R6 register kept");
    wrReg(16, 8'h02);
    pinSet(2, 1'b1);
    check(modFlag[2], 0, "R6 rise ignored in fall mode");
    pinSet(2, 1'b0);
    check(modFlag[2], 1, "R6 fall captured flag");
    rdReg(17, rv);
    check(rv, 8'h15, "R6 fall captured value");
    wrReg(3, 8'h00);
    wrReg(16, 8'h03);
    t0Ticks(1);
    pinSet(2, 1'b1);
    rdReg(17, rv);
    check(rv, 8'h16, "R6 both-edge capture");
    rdReg(18, rv);
    check(rv, 8'h00, "R6 captured high byte");

    // R10 PWM on channel 4
    wrReg(26, 8'h40);
    check(modPinOut[4], 1, "R10 duty 0 before reload");
    t0Ticks(233);
    check(cntValue, 16'h00FF, "R10 count at FF");
    check(modPinOut[4], 1, "R10 shadow not yet active");
    t0Ticks(1);
    check(modPinOut[4], 0, "R10 low after reload");
    t0Ticks(63);
    check(modPinOut[4], 0, "R10 low below duty");
    t0Ticks(1);
    check(modPinOut[4], 1, "R10 high at duty");

    // R4 wrap and overflow flag
    t0Ticks(16'hFFFF - 16'h0140);
    check(cntValue, 16'hFFFF, "R4 at max");
    check(cntOvf, 0, "R4 no ovf yet");
    t0Ticks(1);
    check(cntValue, 0, "R4 wrapped");
    check(cntOvf, 1, "R4 ovf set");
    wrReg(0, 8'h0D);
    rdReg(0, rv);
    check(rv, 8'h0D, "R4 write one keeps ovf");
    wrReg(0, 8'h05);
    rdReg(0, rv);
    check(rv, 8'h05, "R4 write zero clears ovf");

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule